// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Snapshot Readout

This block keeps wall-clock time and date in packed BCD. The fields are seconds, minutes, hours (0 to 23), day of month, month, a two-digit year for 2000 to 2099, and a weekday from 1 to 7, where 7 means Sunday. A slow tick-enable input, nominally 32.768 kHz, drives a prescaler. The prescaler produces one seconds step per `TICKS_PER_SEC` enables. That step ripples through the calendar carry chain, which knows the month lengths and the leap years.

Software reaches the block through a byte-wide synchronous register port. To set the clock, software raises the stop bit in the control byte, writes the fields one by one, and then drops the stop bit. To read a consistent time, software writes the control byte with the capture bit set. That write freezes a copy of all seven fields in one cycle. Software then sets the view bit, so that time reads return the frozen copy while the live counters keep running.

Top module: `bcd_rtc`

## Requirements
- R1: While running, the seconds field steps once per `TICKS_PER_SEC` asserted `tick_en` cycles. While stopped, the prescaler is held at zero, so the first step after resuming comes exactly `TICKS_PER_SEC` enables later.
- R2: Carries ripple in this order: seconds 0x59 to 0x00 bumps minutes, minutes 0x59 to 0x00 bumps hours, and hours 0x23 to 0x00 starts a new day.
- R3: A new day also steps the weekday (offset 0x06), which wraps from 0x07 to 0x01.
- R4: The day of month (offset 0x03) wraps to 0x01 after day 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 in the other months. In month 0x02 it wraps after 0x29 when the year value is divisible by 4, and after 0x28 otherwise.
- R5: When the day wraps, the month (offset 0x04) steps, and month 0x12 wraps to 0x01 with a year step. The year (offset 0x05) wraps from 0x99 to 0x00.
- R6: Control byte bit 0 (offset 0x10) is the stop bit. While it is set, no field advances and writes to offsets 0x00 to 0x06 load the fields directly. While it is clear, writes to those offsets are ignored.
- R7: A write to the control byte with bit 6 set copies all seven live fields into the shadow set on that clock edge. No other write changes the shadow.
- R8: When control bit 7 is set, reads of offsets 0x00 to 0x06 return the shadow set. When it is clear, they return the live fields.
- R9: Control bits 5 to 1 are read/write storage with no effect on counting.
- R10: Offsets 0x12, 0x13 and 0x14 are plain read/write bytes that reset to 0x00. Offsets 0x17 and 0x18 return the `ID_NAME` and `ID_REV` constants and ignore writes.
- R11: Reads of any other offset return 0x00, and writes there change nothing. After reset, every register reads 0x00 except day 0x01, month 0x01 and weekday 0x01.
- R12: `rdata` is registered. It takes the addressed value on the edge where `rd_en` is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow time-base enable, one cycle wide |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check the following:
- the live fields change only on a seconds step or an accepted load;
- no step is made while the stop bit is set;
- the shadow is either an exact copy of the previous cycle's live time or unchanged;
- a weekday of 7 and a year of 99 wrap correctly on the carry events;
- unmapped reads return zero.

Only the bench's scenarios can show that the month lengths and the leap rule are right, that the full carry chain resolves to the correct next date, and that the register-level behaviour holds: the snapshot staying frozen while the live time moves, writes being ignored while running, and the identification bytes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_MDAY = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_IRQEN = 8'h12;
  localparam logic [7:0] A_TRIML = 8'h13;
  localparam logic [7:0] A_TRIMH = 8'h14;
  localparam logic [7:0] A_NAME  = 8'h17;
  localparam logic [7:0] A_REV   = 8'h18;

  typedef logic [NFIELD-1:0][7:0] rtc_fields_t;

  localparam rtc_fields_t FIELDS_RST =
    {8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // BCD increment with digit carry
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] b;
    b = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  // last valid day of a month, in BCD
  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic hold,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  assign sec_pulse = tick_en && !hold && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (hold)               cnt <= '0;
    else if (tick_en)            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        hold,
  input  logic        ld_en,
  input  logic [2:0]  ld_idx,
  input  logic [7:0]  ld_val,
  output rtc_fields_t fields,
  output logic        day_roll,
  output logic        year_roll
);
  rtc_fields_t nxt;
  logic adv, s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, mon_roll;

  assign adv      = step && !hold;
  assign s_wrap   = fields[F_SEC]  == 8'h59;
  assign m_wrap   = fields[F_MIN]  == 8'h59;
  assign h_wrap   = fields[F_HOUR] == 8'h23;
  assign d_wrap   = fields[F_MDAY] == month_last(fields[F_MON], fields[F_YEAR]);
  assign mo_wrap  = fields[F_MON]  == 8'h12;
  assign day_roll  = adv && s_wrap && m_wrap && h_wrap;
  assign mon_roll  = day_roll && d_wrap;
  assign year_roll = mon_roll && mo_wrap;

  always_comb begin
    nxt = fields;
    if (adv)
      nxt[F_SEC] = s_wrap ? 8'h00 : bcd_inc(fields[F_SEC]);
    if (adv && s_wrap)
      nxt[F_MIN] = m_wrap ? 8'h00 : bcd_inc(fields[F_MIN]);
    if (adv && s_wrap && m_wrap)
      nxt[F_HOUR] = h_wrap ? 8'h00 : bcd_inc(fields[F_HOUR]);
    if (day_roll) begin
      nxt[F_MDAY] = d_wrap ? 8'h01 : bcd_inc(fields[F_MDAY]);
      nxt[F_WDAY] = (fields[F_WDAY] == 8'h07) ? 8'h01 : bcd_inc(fields[F_WDAY]);
    end
    if (mon_roll)
      nxt[F_MON] = mo_wrap ? 8'h01 : bcd_inc(fields[F_MON]);
    if (year_roll)
      nxt[F_YEAR] = (fields[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(fields[F_YEAR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields <= FIELDS_RST;
    else if (ld_en) fields[ld_idx] <= ld_val;
    else            fields <= nxt;
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int         TICKS_PER_SEC = 32768,
  parameter logic [7:0] ID_NAME       = 8'hC3,
  parameter logic [7:0] ID_REV        = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata
);
  logic [7:0]  ctrl_q, irqen_q, triml_q, trimh_q, rd_mux;
  rtc_fields_t live, shadow;
  logic        stop, view_shadow, sec_pulse, day_roll, year_roll;
  logic        time_addr, tm_wr, snap_take, rd_unmapped;

  assign stop        = ctrl_q[0];
  assign view_shadow = ctrl_q[7];
  assign time_addr   = addr < 8'(NFIELD);
  assign tm_wr       = wr_en && time_addr && stop;
  assign snap_take   = wr_en && (addr == A_CTRL) && wdata[6];

  rtc_sec_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold(stop), .sec_pulse(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(sec_pulse), .hold(stop),
    .ld_en(tm_wr), .ld_idx(addr[2:0]), .ld_val(wdata),
    .fields(live), .day_roll(day_roll), .year_roll(year_roll)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      irqen_q <= 8'h00;
      triml_q <= 8'h00;
      trimh_q <= 8'h00;
      shadow  <= FIELDS_RST;
    end else begin
      if (snap_take) shadow <= live;
      if (wr_en) begin
        case (addr)
          A_CTRL:  ctrl_q  <= wdata;
          A_IRQEN: irqen_q <= wdata;
          A_TRIML: triml_q <= wdata;
          A_TRIMH: trimh_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_unmapped = 1'b0;
    rd_mux      = 8'h00;
    if (time_addr) rd_mux = view_shadow ? shadow[addr[2:0]] : live[addr[2:0]];
    else begin
      case (addr)
        A_CTRL:  rd_mux = ctrl_q;
        A_IRQEN: rd_mux = irqen_q;
        A_TRIML: rd_mux = triml_q;
        A_TRIMH: rd_mux = trimh_q;
        A_NAME:  rd_mux = ID_NAME;
        A_REV:   rd_mux = ID_REV;
        default: rd_unmapped = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        stop,
  input logic        sec_pulse,
  input logic        tm_wr,
  input logic        snap_take,
  input logic        day_roll,
  input logic        year_roll,
  input logic        rd_en,
  input logic        rd_unmapped,
  input logic [55:0] live,
  input logic [55:0] shadow,
  input logic [7:0]  rdata
);
  // R1: live time changes only on a seconds step or a load
  a_r1_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !tm_wr) |=> $stable(live));
  // R6: a stopped clock never steps
  a_r6_stop_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !sec_pulse);
  // R3: weekday 7 wraps to 1 on a new day
  a_r3_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && live[55:48] == 8'h07) |=> live[55:48] == 8'h01);
  // R5: year 99 wraps to 00
  a_r5_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (year_roll && live[47:40] == 8'h99) |=> live[47:40] == 8'h00);
  // R7: capture copies the live set exactly
  a_r7_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |=> shadow == $past(live));
  // R7: shadow frozen without a capture
  a_r7_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(shadow));
  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_unmapped) |=> rdata == 8'h00);
endmodule

bind bcd_rtc bcd_rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .sec_pulse(sec_pulse), .tm_wr(tm_wr),
  .snap_take(snap_take), .day_roll(day_roll), .year_roll(year_roll),
  .rd_en(rd_en), .rd_unmapped(rd_unmapped), .live(live), .shadow(shadow),
  .rdata(rdata)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  localparam int TPS = 4;
  localparam int NV  = 10;
  // each entry: {start time, expected time one second later};
  // byte order in a time word, high to low: wday year mon mday hour min sec
  localparam logic [NV-1:0][111:0] VEC = {
    {56'h04_24_02_29_23_59_59, 56'h05_24_03_01_00_00_00},  // R4 leap Feb 29 end
    {56'h03_24_02_28_23_59_59, 56'h04_24_02_29_00_00_00},  // R4 leap day entry
    {56'h02_23_02_28_23_59_59, 56'h03_23_03_01_00_00_00},  // R4 non-leap Feb
    {56'h06_21_11_30_23_59_59, 56'h07_21_12_01_00_00_00},  // R4 November 30 days
    {56'h05_22_04_30_23_59_59, 56'h06_22_05_01_00_00_00},  // R4 April
    {56'h01_22_01_30_23_59_59, 56'h02_22_01_31_00_00_00},  // R4 Jan has 31
    {56'h07_99_12_31_23_59_59, 56'h01_00_01_01_00_00_00},  // R5 R3 year rollover
    {56'h02_30_06_15_09_59_59, 56'h02_30_06_15_10_00_00},  // R2 hour carry
    {56'h03_24_05_15_00_09_59, 56'h03_24_05_15_00_10_00},  // R2 minute carry
    {56'h03_24_05_15_12_34_56, 56'h03_24_05_15_12_34_57}   // R1 plain step
  };

  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic check(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] got;
    rd(a, got);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr %02h: got %02h expected %02h", req, a, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic load_time(input logic [55:0] t);
    wr(8'h10, 8'h01);
    for (int i = 0; i < 7; i++) wr(8'(i), t[i*8 +: 8]);
    wr(8'h10, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset values
    check("R11", 8'h00, 8'h00); check("R11", 8'h03, 8'h01);
    check("R11", 8'h04, 8'h01); check("R11", 8'h06, 8'h01);
    check("R11", 8'h10, 8'h00); check("R10", 8'h13, 8'h00);

    // vector table: R1..R5
    for (int k = 0; k < NV; k++) begin
      load_time(VEC[k][111:56]);
      ticks(TPS);
      for (int f = 0; f < 7; f++) check("R1-table R2 R3 R4 R5", 8'(f), VEC[k][f*8 +: 8]);
    end

    // R1 prescaler phase: no step before TPS enables
    load_time(56'h01_24_05_15_12_00_20);
    ticks(TPS - 1);
    check("R1", 8'h00, 8'h20);
    ticks(1);
    check("R1", 8'h00, 8'h21);

    // R6 writes ignored while running, stop holds time
    wr(8'h00, 8'h45);
    check("R6", 8'h00, 8'h21);
    wr(8'h10, 8'h01);
    ticks(3 * TPS);
    check("R6", 8'h00, 8'h21);
    wr(8'h00, 8'h40);
    check("R6", 8'h00, 8'h40);
    wr(8'h10, 8'h00);

    // R7 R8 snapshot frozen while live advances
    wr(8'h10, 8'h40);
    ticks(2 * TPS);
    wr(8'h10, 8'h80);
    check("R8", 8'h00, 8'h40);
    check("R7", 8'h02, 8'h12);
    ticks(TPS);
    check("R7", 8'h00, 8'h40);
    wr(8'h10, 8'h00);
    check("R8", 8'h00, 8'h43);

    // R9 storage bits, clock keeps running
    wr(8'h10, 8'h3E);
    check("R9", 8'h10, 8'h3E);
    ticks(TPS);
    check("R9", 8'h00, 8'h44);
    wr(8'h10, 8'h00);

    // R10 plain bytes and id constants
    wr(8'h13, 8'hA5); wr(8'h14, 8'h5A); wr(8'h12, 8'h3C);
    check("R10", 8'h13, 8'hA5); check("R10", 8'h14, 8'h5A); check("R10", 8'h12, 8'h3C);
    wr(8'h17, 8'h00);
    check("R10", 8'h17, 8'hC3); check("R10", 8'h18, 8'h21);

    // R11 unmapped
    wr(8'h20, 8'h55);
    check("R11", 8'h20, 8'h00); check("R11", 8'h07, 8'h00);

    // R12 rdata holds without rd_en
    rd(8'h13, v);
    @(negedge clk); addr = 8'h17;
    @(negedge clk);
    n_run++;
    if (rdata !== 8'hA5) begin
      n_fail++;
      $display("FAIL R12 hold: got %02h expected a5", rdata);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule